// File: doc/BRIEF.md
# Link Event Counter Bank

This block holds a bank of saturating event counters for the physical layer of a serial storage link. The link layer gives it one single-cycle strobe per counter. A counter can record events seen during data frame transfers, events seen during non-data frame transfers, or events not tied to any frame. Frame counters are further tagged as host-to-device, device-to-host or bidirectional. Each counter has its own strobe, so one link event can raise several counters in the same cycle. For example, a disparity error can raise both a CRC-error counter and a non-CRC-error counter. A bidirectional counter counts its own strobe and is never formed by summing the per-direction counters.

The host reads the counters through a log-read port. A request for log page 11h copies every counter into a snapshot in a single cycle. The host then pops the snapshot out one entry at a time as identifier/value pairs, and a zero identifier ends the stream. If the request also carries the clear flag (bit 0 of the read's features field), the counters are cleared after the snapshot is taken. Receiving a BIST Activate frame also clears the counters. Link resets and software resets leave the counts alone. Only the power-on reset zeroes the bank. A capability output reports that the feature is present.

Top module: `link_evt_ctr_bank`

## Requirements
- R1: After power-on reset every counter reads zero, `rd_vld_o` is low and `cap_o` is high.
- R2: Each cycle that strobe bit k of `evt_i` is high adds one to counter k. Several strobes in the same cycle each count. A counter never changes on another counter's strobe.
- R3: A counter that has reached 65535 (16 bits) stays at 65535 on further strobes. It does not wrap.
- R4: Pulses on `link_rst_i` or `sw_rst_i` leave every counter value unchanged. A pulse also ends any readout in progress, so `rd_vld_o` is low in the following cycle.
- R5: A `bist_i` pulse sets every counter to zero. A strobe in that same cycle is counted after the clear, which leaves that counter at 1.
- R6: A read with `rd_page_i` = 8'h11 captures the counter values as they stood before that cycle's edge. Events during the readout do not change the streamed values.
- R7: The stream presents counter k with identifier k+1, in ascending k, one entry per `rd_pop_i`. It then presents identifier 0 with value 0. A pop on that terminator drops `rd_vld_o`.
- R8: A page-11h read with `rd_clr_i` (features bit 0) = 1 streams the pre-clear values and then leaves every counter at zero. A strobe in the request cycle is counted after the clear, which leaves that counter at 1.
- R9: A read with any page other than 8'h11 starts no stream and clears nothing, even when `rd_clr_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| evt_i | input | NUM_CTR | One event strobe per counter |
| link_rst_i | input | 1 | Link-level reset seen on the link |
| sw_rst_i | input | 1 | Software reset seen on the link |
| bist_i | input | 1 | BIST Activate frame received |
| rd_req_i | input | 1 | Log read request strobe |
| rd_page_i | input | 8 | Log page number of the request |
| rd_clr_i | input | 1 | Features bit 0 of the request: clear after read |
| rd_pop_i | input | 1 | Advance to the next stream entry |
| rd_vld_o | output | 1 | Stream entry valid |
| rd_id_o | output | ID_W | Counter identifier, 0 marks the end |
| rd_val_o | output | CTR_W | Snapshot value of the entry |
| cap_o | output | 1 | Counter feature supported |

## Verification
Counters are first loaded with a staircase pattern, where counter k receives k+1 strobes. Distinct values per counter expose a swapped, shifted or merged strobe lane, and they also expose a stream that is out of order. Strobes that are all high in the same cycle show that simultaneous events each count. Events are injected during a readout and in the very cycle of a clear, which separates snapshot-then-clear from clear-then-count orderings. A long run on one strobe reaches the 16-bit ceiling to tell saturation from wrap. Resets, foreign pages and BIST pulses are each followed by a full readout that compares every counter.

// File: rtl/lec_pkg.sv
package lec_pkg;
    localparam int          CTR_W_DEF    = 16;
    localparam int          NUM_CTR_DEF  = 8;
    localparam int          ID_W_DEF     = 8;
    localparam logic [7:0]  LOG_PAGE_DEF = 8'h11;

    typedef enum logic [1:0] {
        GRP_DATA_FRAME,
        GRP_CTRL_FRAME,
        GRP_NO_FRAME
    } ctr_grp_e;

    typedef enum logic [1:0] {
        DIR_TO_DEV,
        DIR_TO_HOST,
        DIR_BOTH,
        DIR_NONE
    } ctr_dir_e;
endpackage

// File: rtl/lec_ctr_cell.sv
module lec_ctr_cell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.cnt = '0;
        if (inc_i && (st_d.cnt != MAX)) st_d.cnt = st_d.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (cnt_o == MAX && !clr_i) |=> (cnt_o == MAX)); // R3
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i && !inc_i) |=> (cnt_o == '0)); // R5
    AST_CLR_THEN_CNT: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i && inc_i) |=> (cnt_o == W'(1))); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_i && !inc_i) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/lec_ctr_bank.sv
module lec_ctr_bank #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                clr_i,
    input  logic [N-1:0]        inc_i,
    output logic [N-1:0][W-1:0] cnt_o
);
    for (genvar k = 0; k < N; k++) begin : g_cell
        lec_ctr_cell #(.W(W)) u_cell (
            .clk   (clk),
            .por_n (por_n),
            .clr_i (clr_i),
            .inc_i (inc_i[k]),
            .cnt_o (cnt_o[k])
        );
    end
endmodule

// File: rtl/lec_rd_stream.sv
module lec_rd_stream #(
    parameter int N    = 8,
    parameter int W    = 16,
    parameter int ID_W = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                take_i,
    input  logic                abort_i,
    input  logic                pop_i,
    input  logic [N-1:0][W-1:0] cnt_i,
    output logic                vld_o,
    output logic [ID_W-1:0]     id_o,
    output logic [W-1:0]        val_o
);
    localparam int             IW   = $clog2(N + 1);
    localparam logic [IW-1:0]  LAST = IW'(N);

    typedef struct packed {
        logic                busy;
        logic [IW-1:0]       idx;
        logic [N-1:0][W-1:0] snap;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.snap = cnt_i;
        end else if (abort_i) begin
            st_d.busy = 1'b0;
        end else if (pop_i && st_q.busy) begin
            if (st_q.idx == LAST) st_d.busy = 1'b0;
            else                  st_d.idx  = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        val_o = '0;
        for (int k = 0; k < N; k++) begin
            if (st_q.idx == IW'(k)) val_o = st_q.snap[k];
        end
        id_o = (st_q.idx == LAST) ? '0 : ID_W'(st_q.idx) + 1'b1;
    end

    assign vld_o = st_q.busy;

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        (vld_o && !take_i) |=> $stable(st_q.snap)); // R6
    AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!por_n)
        (vld_o && pop_i && id_o == '0 && !take_i) |=> !vld_o); // R7
    AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (vld_o && id_o == '0) |-> (val_o == '0)); // R7
    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!por_n)
        (abort_i && !take_i) |=> !vld_o); // R4
endmodule

// File: rtl/link_evt_ctr_bank.sv
module link_evt_ctr_bank #(
    parameter int         NUM_CTR  = lec_pkg::NUM_CTR_DEF,
    parameter int         CTR_W    = lec_pkg::CTR_W_DEF,
    parameter int         ID_W     = lec_pkg::ID_W_DEF,
    parameter logic [7:0] LOG_PAGE = lec_pkg::LOG_PAGE_DEF
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [NUM_CTR-1:0] evt_i,
    input  logic               link_rst_i,
    input  logic               sw_rst_i,
    input  logic               bist_i,
    input  logic               rd_req_i,
    input  logic [7:0]         rd_page_i,
    input  logic               rd_clr_i,
    input  logic               rd_pop_i,
    output logic               rd_vld_o,
    output logic [ID_W-1:0]    rd_id_o,
    output logic [CTR_W-1:0]   rd_val_o,
    output logic               cap_o
);
    logic                            take;
    logic                            clr_all;
    logic [NUM_CTR-1:0][CTR_W-1:0]   cnt;

    assign take    = rd_req_i && (rd_page_i == LOG_PAGE);
    assign clr_all = bist_i || (take && rd_clr_i);
    assign cap_o   = 1'b1;

    lec_ctr_bank #(.N(NUM_CTR), .W(CTR_W)) u_bank (
        .clk   (clk),
        .por_n (por_n),
        .clr_i (clr_all),
        .inc_i (evt_i),
        .cnt_o (cnt)
    );

    lec_rd_stream #(.N(NUM_CTR), .W(CTR_W), .ID_W(ID_W)) u_rd (
        .clk     (clk),
        .por_n   (por_n),
        .take_i  (take),
        .abort_i (link_rst_i || sw_rst_i),
        .pop_i   (rd_pop_i),
        .cnt_i   (cnt),
        .vld_o   (rd_vld_o),
        .id_o    (rd_id_o),
        .val_o   (rd_val_o)
    );

    AST_FOREIGN_PAGE: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req_i && rd_page_i != LOG_PAGE && !rd_vld_o) |=> !rd_vld_o); // R9
    AST_STREAM_START: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req_i && rd_page_i == LOG_PAGE) |=> (rd_vld_o && rd_id_o == ID_W'(1))); // R6
endmodule

// File: tb/link_evt_ctr_bank_test.sv
module link_evt_ctr_bank_test;
    localparam int PERIOD = 10;
    localparam int N      = 8;
    localparam int W      = 16;
    localparam int ID_W   = 8;
    localparam int MAXV   = 65535;

    logic           clk = 1'b0;
    logic           por_n = 1'b0;
    logic [N-1:0]   evt_i = '0;
    logic           link_rst_i = 1'b0, sw_rst_i = 1'b0, bist_i = 1'b0;
    logic           rd_req_i = 1'b0, rd_clr_i = 1'b0, rd_pop_i = 1'b0;
    logic [7:0]     rd_page_i = '0;
    logic           rd_vld_o, cap_o;
    logic [ID_W-1:0] rd_id_o;
    logic [W-1:0]   rd_val_o;

    int vectors = 0;
    int errors  = 0;
    int model [N];
    int snap  [N];

    always #(PERIOD/2) clk = ~clk;

    link_evt_ctr_bank #(.NUM_CTR(N), .CTR_W(W), .ID_W(ID_W)) uut (
        .clk(clk), .por_n(por_n), .evt_i(evt_i), .link_rst_i(link_rst_i),
        .sw_rst_i(sw_rst_i), .bist_i(bist_i), .rd_req_i(rd_req_i),
        .rd_page_i(rd_page_i), .rd_clr_i(rd_clr_i), .rd_pop_i(rd_pop_i),
        .rd_vld_o(rd_vld_o), .rd_id_o(rd_id_o), .rd_val_o(rd_val_o), .cap_o(cap_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: inputs held from negedge, model follows at posedge
    task automatic tick(input logic [N-1:0] ev, input bit bist, input bit req,
                        input logic [7:0] page, input bit clr, input bit lrst,
                        input bit srst, input bit pop);
        evt_i = ev; bist_i = bist; rd_req_i = req; rd_page_i = page;
        rd_clr_i = clr; link_rst_i = lrst; sw_rst_i = srst; rd_pop_i = pop;
        @(posedge clk);
        for (int k = 0; k < N; k++) begin
            int b;
            b = (bist || (req && page == 8'h11 && clr)) ? 0 : model[k];
            if (ev[k] && b < MAXV) b++;
            model[k] = b;
        end
        @(negedge clk);
        evt_i = '0; bist_i = 0; rd_req_i = 0; rd_clr_i = 0;
        link_rst_i = 0; sw_rst_i = 0; rd_pop_i = 0;
    endtask

    task automatic idle(input logic [N-1:0] ev);
        tick(ev, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic read_all(input bit clr, input logic [N-1:0] ev_req,
                            input logic [N-1:0] ev_pop, input string tag);
        for (int k = 0; k < N; k++) snap[k] = model[k];
        tick(ev_req, 0, 1, 8'h11, clr, 0, 0, 0);
        chk({tag, " R6 vld"}, int'(rd_vld_o), 1);
        for (int k = 0; k < N; k++) begin
            chk({tag, " R7 id"}, int'(rd_id_o), k + 1);
            chk({tag, " R6 val"}, int'(rd_val_o), snap[k]);
            tick(ev_pop, 0, 0, 8'h00, 0, 0, 0, 1);
        end
        chk({tag, " R7 term id"}, int'(rd_id_o), 0);
        chk({tag, " R7 term val"}, int'(rd_val_o), 0);
        tick('0, 0, 0, 8'h00, 0, 0, 0, 1);
        chk({tag, " R7 end"}, int'(rd_vld_o), 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) model[k] = 0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 vld", int'(rd_vld_o), 0);
        chk("R1 cap", int'(cap_o), 1);
        read_all(0, '0, '0, "R1 zeros");

        // R2 staircase: counter k gets k+1 strobes
        for (int r = 0; r < N; r++) idle(N'('1) << r);
        idle('1); idle('1);
        read_all(0, 8'hAA, 8'h55, "R2 stair");
        read_all(0, '0, '0, "R2 accum");

        // R4 resets leave counts, and abort a stream
        tick('0, 0, 0, 8'h00, 0, 1, 0, 0);
        tick('0, 0, 0, 8'h00, 0, 0, 1, 0);
        tick('0, 0, 1, 8'h11, 0, 0, 0, 0);
        tick('0, 0, 0, 8'h00, 0, 0, 0, 1);
        tick('0, 0, 0, 8'h00, 0, 1, 0, 0);
        chk("R4 link abort", int'(rd_vld_o), 0);
        tick('0, 0, 1, 8'h11, 0, 0, 0, 0);
        tick('0, 0, 0, 8'h00, 0, 0, 1, 0);
        chk("R4 sw abort", int'(rd_vld_o), 0);
        read_all(0, '0, '0, "R4 kept");

        // R9 foreign page with clear flag
        tick('0, 0, 1, 8'h10, 1, 0, 0, 0);
        chk("R9 no stream", int'(rd_vld_o), 0);
        tick('0, 0, 1, 8'h91, 1, 0, 0, 0);
        chk("R9 no stream hi", int'(rd_vld_o), 0);
        read_all(0, '0, '0, "R9 kept");

        // R8 read-and-clear, strobe in the request cycle
        read_all(1, 8'h01, '0, "R8 preclear");
        read_all(0, '0, '0, "R8 after");

        // R5 BIST clear with coincident strobe
        idle('1); idle(8'hF0);
        tick(8'h02, 1, 0, 8'h00, 0, 0, 0, 0);
        read_all(0, '0, '0, "R5 bist");

        // R3 saturation on counter 3
        for (int i = 0; i < MAXV + 5; i++) idle(8'h08);
        read_all(0, 8'h08, 8'h08, "R3 sat");
        chk("R3 model", model[3], MAXV);
        read_all(0, '0, '0, "R3 hold");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule